// File: doc/BRIEF.md
# Single-Channel Byte DMA Transfer Engine

This block is one channel of a byte-wide direct memory access controller. Software loads a source address, a destination address and a transfer count. When the attached device raises its request, the channel asks an external arbiter for the system bus. Once the bus is granted, it steps through consecutive byte addresses and issues the memory and I/O strobes for each transfer. It asserts terminal count on the last byte.

Three transfer kinds are supported:
- **Read:** memory data goes to the device.
- **Write:** device data goes to memory.
- **Memory-to-memory:** each byte is read into an internal holding register and then written to a second address.

In single mode the bus is handed back after every byte. In block mode it is kept until the count runs out.

The address leaves the channel in two pieces. The low byte is on its own port. The high byte is placed on the data port in an address cycle, together with a strobe that lets an external latch capture it. That address cycle is only inserted when the high byte must change, and always at the start of a service, so runs within one 256-byte page need one clock per byte.

Base registers are kept separate from the working copies. With auto-reload enabled, a finished block restores its addresses and count and stays ready.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset, bus_req, dev_ack, addr_stb, data_oe, tc and all four bus strobes are low. The channel does not respond to dev_req until a count has been written.
- R2: A programming write (prog_sel 0 = source address, 1 = destination address, 2 = count) loads both the base and the working copy of that register. Transfers leave the base value untouched.
- R3: The source address (and, for memory-to-memory, the destination address) advances by one per byte moved, wrapping from all ones to zero. The full address seen by memory is {latched high byte, addr_lo}.
- R4: In an address cycle, addr_stb is high and data_out carries the high address byte with data_oe high. Such a cycle occurs at the first access of every service, and otherwise only when the high byte differs from the last value strobed.
- R5: The count decrements once per byte moved. tc is high for one clock, in the data cycle of the byte during which the count passes from zero to all ones, so a programmed count N moves N+1 bytes.
- R6: In single mode (cfg_block = 0), bus_req falls in the clock after each byte and rises again while dev_req stays high.
- R7: In block mode (cfg_block = 1), bus_req stays high from the first grant until tc, whatever dev_req does.
- R8: Read kind (cfg_type 0): each data cycle asserts mem_rd, io_wr and dev_ack together, and the data port is not driven.
- R9: Write kind (cfg_type 1): each data cycle asserts io_rd, mem_wr and dev_ack together, and the data port is not driven.
- R10: Memory-to-memory kind (cfg_type 2): each byte is a mem_rd cycle at the source that captures data_in, then a mem_wr cycle at the destination that drives the captured byte on data_out. dev_ack stays low.
- R11: After tc with cfg_autoinit = 0, the channel stays idle until the count is rewritten. With cfg_autoinit = 1, all working registers are restored from their bases and the channel stays ready.
- R12: Bus strobes are only asserted while bus_req and hold_grant are both high, and memory read and write never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Programming write enable |
| prog_sel | input | 2 | Register select: 0 source, 1 destination, 2 count |
| prog_wdata | input | ADDR_W | Programming write value |
| cfg_type | input | 2 | Transfer kind: 0 read, 1 write, 2 memory-to-memory (3 behaves as read) |
| cfg_block | input | 1 | 1 = block mode, 0 = single mode |
| cfg_autoinit | input | 1 | Reload working registers from bases at terminal count |
| dev_req | input | 1 | Service request from the device |
| dev_ack | output | 1 | Acknowledge to the device during its data cycles |
| bus_req | output | 1 | Bus request to the arbiter |
| hold_grant | input | 1 | Bus grant from the arbiter |
| addr_lo | output | DATA_W | Low address byte |
| data_in | input | DATA_W | Data bus input (memory read data) |
| data_out | output | DATA_W | Data bus output: high address byte or held data |
| data_oe | output | 1 | Data bus output enable |
| addr_stb | output | 1 | Strobe for the external high-address latch |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| tc | output | 1 | Terminal count |

## Verification
The bench builds the channel with its default parameters: 16-bit addresses, 8-bit data, a 16-bit count and the strobe-on-change variant of the address latch logic. With these values, starting addresses placed near the end of a 256-byte page make page crossings, and the wrap from all ones to zero, happen within a few bytes. Short counts reach the zero-to-all-ones count wrap that ends each block. An external latch model rebuilds the full address from the strobe, so a missing or stale address cycle shows up as a wrong memory address.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

   typedef enum logic [1:0] {
      XF_READ  = 2'd0,
      XF_WRITE = 2'd1,
      XF_M2M   = 2'd2,
      XF_RSVD  = 2'd3
   } xfer_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HOLD = 2'd1,
      ST_ADR  = 2'd2,
      ST_DAT  = 2'd3
   } seq_e;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;

endpackage

// File: rtl/dma_reg_pair.sv
// Base/working register pair: a write sets both, reload copies base into
// working, step moves the working copy by one in the chosen direction.
module dma_reg_pair #(
   parameter int W          = 16,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic         step,
   input  logic         reload,
   output logic [W-1:0] cur_q
);

   logic [W-1:0] base_q;
   logic [W-1:0] stepped;

   generate
      if (COUNT_DOWN) begin : g_down
         assign stepped = cur_q - W'(1);
      end else begin : g_up
         assign stepped = cur_q + W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (wr_en) begin
         base_q <= wr_val;
         cur_q  <= wr_val;
      end else if (reload) begin
         cur_q  <= base_q;
      end else if (step) begin
         cur_q  <= stepped;
      end
   end

endmodule

// File: rtl/dma_hi_track.sv
// Remembers the high address byte last handed to the external latch and
// says whether the upcoming access needs a fresh address cycle.
module dma_hi_track #(
   parameter int HW        = 8,
   parameter bit ON_CHANGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          take,
   input  logic [HW-1:0] cap_hi,
   input  logic [HW-1:0] cmp_hi,
   output logic          need
);

   generate
      if (ON_CHANGE) begin : g_change
         logic [HW-1:0] last_q;
         logic          valid_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q  <= '0;
               valid_q <= 1'b0;
            end else if (clear) begin
               valid_q <= 1'b0;
            end else if (take) begin
               last_q  <= cap_hi;
               valid_q <= 1'b1;
            end
         end

         assign need = !valid_q || (cmp_hi != last_q);
      end else begin : g_always
         logic unused_in;
         assign unused_in = ^{clk, rst_n, clear, take, cap_hi, cmp_hi};
         assign need      = 1'b1 | unused_in;
      end
   endgenerate

endmodule

// File: rtl/dma_seq.sv
// Service sequencer: idle, bus hold, optional address cycle, data cycles.
module dma_seq
   import dma_ch_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  armed,
   input  logic  dev_req,
   input  logic  hold_grant,
   input  xfer_e xfer,
   input  logic  cfg_block,
   input  logic  cfg_autoinit,
   input  logic  need_stb,
   input  logic  cnt_zero,
   output seq_e  st_q,
   output logic  dst_q,
   output logic  step_src,
   output logic  step_dst,
   output logic  step_cnt,
   output logic  reload,
   output logic  set_done,
   output logic  trk_clear,
   output logic  tc,
   output logic  bus_req,
   output logic  dev_ack,
   output logic  mem_rd,
   output logic  mem_wr,
   output logic  io_rd,
   output logic  io_wr
);

   seq_e st_d;
   logic dst_d;
   logic is_m2m, is_wr, is_rd;
   logic in_dat, byte_done;

   assign is_m2m    = (xfer == XF_M2M);
   assign is_wr     = (xfer == XF_WRITE);
   assign is_rd     = !is_m2m && !is_wr;
   assign in_dat    = (st_q == ST_DAT);
   assign byte_done = !is_m2m || dst_q;

   always_comb begin
      st_d      = st_q;
      dst_d     = dst_q;
      step_src  = 1'b0;
      step_dst  = 1'b0;
      step_cnt  = 1'b0;
      reload    = 1'b0;
      set_done  = 1'b0;
      trk_clear = 1'b0;
      tc        = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (armed && dev_req) begin
               st_d      = ST_HOLD;
               dst_d     = 1'b0;
               trk_clear = 1'b1;
            end
         end
         ST_HOLD: begin
            if (hold_grant) st_d = ST_ADR;
         end
         ST_ADR: begin
            st_d = ST_DAT;
         end
         ST_DAT: begin
            step_src = !is_m2m || !dst_q;
            step_dst = is_m2m && dst_q;
            step_cnt = byte_done;
            if (byte_done && cnt_zero) begin
               tc       = 1'b1;
               st_d     = ST_IDLE;
               dst_d    = 1'b0;
               reload   = cfg_autoinit;
               set_done = !cfg_autoinit;
            end else if (byte_done && !cfg_block) begin
               st_d  = ST_IDLE;
               dst_d = 1'b0;
            end else begin
               st_d  = need_stb ? ST_ADR : ST_DAT;
               dst_d = is_m2m && !dst_q;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         dst_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         dst_q <= dst_d;
      end
   end

   assign bus_req = (st_q != ST_IDLE);
   assign dev_ack = in_dat && !is_m2m;
   assign mem_rd  = in_dat && (is_rd || (is_m2m && !dst_q));
   assign mem_wr  = in_dat && (is_wr || (is_m2m && dst_q));
   assign io_rd   = in_dat && is_wr;
   assign io_wr   = in_dat && is_rd;

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
   import dma_ch_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int CNT_W         = 16,
   parameter bit STB_ON_CHANGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_we,
   input  logic [1:0]        prog_sel,
   input  logic [ADDR_W-1:0] prog_wdata,
   input  logic [1:0]        cfg_type,
   input  logic              cfg_block,
   input  logic              cfg_autoinit,
   input  logic              dev_req,
   output logic              dev_ack,
   output logic              bus_req,
   input  logic              hold_grant,
   output logic [DATA_W-1:0] addr_lo,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              addr_stb,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              tc
);

   localparam int HW = ADDR_W - DATA_W;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_split
         $error("dma_xfer_channel: ADDR_W must be twice DATA_W");
      end
      if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
         $error("dma_xfer_channel: CNT_W must lie in 1..ADDR_W");
      end
   endgenerate

   xfer_e             xfer;
   seq_e              st;
   logic              dst_phase, is_m2m;
   logic              step_src, step_dst, step_cnt, reload, set_done, trk_clear;
   logic              need_stb, done_q, cnt_zero;
   logic [ADDR_W-1:0] src_cur, dst_cur, cur_addr, next_addr;
   logic [CNT_W-1:0]  cnt_cur;
   logic [DATA_W-1:0] temp_q;
   logic              wr_src, wr_dst, wr_cnt;

   assign xfer   = xfer_e'(cfg_type);
   assign is_m2m = (xfer == XF_M2M);
   assign wr_src = prog_we && (prog_sel == SEL_SRC);
   assign wr_dst = prog_we && (prog_sel == SEL_DST);
   assign wr_cnt = prog_we && (prog_sel == SEL_CNT);

   dma_reg_pair #(.W(ADDR_W), .COUNT_DOWN(1'b0)) u_src (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_src), .wr_val(prog_wdata),
      .step(step_src), .reload(reload), .cur_q(src_cur)
   );

   dma_reg_pair #(.W(ADDR_W), .COUNT_DOWN(1'b0)) u_dst (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_dst), .wr_val(prog_wdata),
      .step(step_dst), .reload(reload), .cur_q(dst_cur)
   );

   dma_reg_pair #(.W(CNT_W), .COUNT_DOWN(1'b1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_cnt), .wr_val(prog_wdata[CNT_W-1:0]),
      .step(step_cnt), .reload(reload), .cur_q(cnt_cur)
   );

   assign cnt_zero = (cnt_cur == '0);
   assign cur_addr = dst_phase ? dst_cur : src_cur;

   // Address used by the access after the current data cycle.
   always_comb begin
      if (is_m2m) next_addr = dst_phase ? src_cur : dst_cur;
      else        next_addr = src_cur + ADDR_W'(1);
   end

   dma_hi_track #(.HW(HW), .ON_CHANGE(STB_ON_CHANGE)) u_hi (
      .clk(clk), .rst_n(rst_n), .clear(trk_clear), .take(st == ST_ADR),
      .cap_hi(cur_addr[ADDR_W-1:DATA_W]), .cmp_hi(next_addr[ADDR_W-1:DATA_W]),
      .need(need_stb)
   );

   dma_seq u_seq (
      .clk(clk), .rst_n(rst_n), .armed(!done_q), .dev_req(dev_req),
      .hold_grant(hold_grant), .xfer(xfer), .cfg_block(cfg_block),
      .cfg_autoinit(cfg_autoinit), .need_stb(need_stb), .cnt_zero(cnt_zero),
      .st_q(st), .dst_q(dst_phase), .step_src(step_src), .step_dst(step_dst),
      .step_cnt(step_cnt), .reload(reload), .set_done(set_done),
      .trk_clear(trk_clear), .tc(tc), .bus_req(bus_req), .dev_ack(dev_ack),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        done_q <= 1'b1;
      else if (wr_cnt)   done_q <= 1'b0;
      else if (set_done) done_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) temp_q <= '0;
      else if (st == ST_DAT && is_m2m && !dst_phase) temp_q <= data_in;
   end

   assign addr_lo  = cur_addr[DATA_W-1:0];
   assign addr_stb = (st == ST_ADR);

   always_comb begin
      data_out = '0;
      data_oe  = 1'b0;
      if (st == ST_ADR) begin
         data_out = cur_addr[ADDR_W-1:DATA_W];
         data_oe  = 1'b1;
      end else if (st == ST_DAT && is_m2m && dst_phase) begin
         data_out = temp_q;
         data_oe  = 1'b1;
      end
   end

endmodule

// File: rtl/dma_xfer_channel_chk.sv
module dma_xfer_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_type,
   input logic       cfg_block,
   input logic       cfg_autoinit,
   input logic       hold_grant,
   input logic       bus_req,
   input logic       dev_ack,
   input logic       data_oe,
   input logic       addr_stb,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       io_rd,
   input logic       io_wr,
   input logic       tc
);

   logic started_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started_q <= 1'b0;
      else        started_q <= 1'b1;
   end

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> (!bus_req && !tc && !addr_stb && !data_oe));

   a_r4_stb_is_addr_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      addr_stb |-> (data_oe && bus_req && !mem_rd && !mem_wr && !io_rd && !io_wr));

   a_r5_tc_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> !tc);

   a_r5_tc_on_byte_end: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (io_wr || mem_wr));

   a_r6_single_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_block && (io_wr || mem_wr)) |=> !bus_req);

   a_r7_block_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_block && (io_wr || mem_wr) && !tc) |=> bus_req);

   a_r8_read_pairing: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr |-> (mem_rd && dev_ack && !data_oe));

   a_r9_write_pairing: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd |-> (mem_wr && dev_ack && !data_oe));

   a_r10_m2m_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_type == 2'd2 && (mem_rd || mem_wr)) |-> (!dev_ack && !io_rd && !io_wr));

   a_r11_stop_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !cfg_autoinit) |=> !bus_req ##1 !bus_req);

   a_r12_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr) |-> (bus_req && hold_grant));

   a_r12_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

endmodule

bind dma_xfer_channel dma_xfer_channel_chk u_chk (.*);

// File: tb/tb_dma_xfer_channel.sv
module tb_dma_xfer_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_we = 1'b0;
   logic [1:0]  prog_sel = 2'd0;
   logic [15:0] prog_wdata = 16'h0;
   logic [1:0]  cfg_type = 2'd0;
   logic        cfg_block = 1'b0;
   logic        cfg_autoinit = 1'b0;
   logic        dev_req = 1'b0;
   logic        hold_grant = 1'b0;
   logic        dev_ack, bus_req, data_oe, addr_stb;
   logic        mem_rd, mem_wr, io_rd, io_wr, tc;
   logic [7:0]  addr_lo, data_in, data_out;

   logic [7:0]  ext_hi = 8'h00;
   int          n_vec = 0;
   int          n_fail = 0;

   // model state
   int          m_type;
   logic [15:0] m_src, m_dst;
   int          m_left;
   bit          m_phase;
   logic [7:0]  m_temp;
   bit          mdl_valid;
   logic [7:0]  mdl_hi;
   bit          svc_stb;
   bit          req_q;
   int          svc_cnt;
   bit          mon_on = 1'b0;

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[15:8] ^ (a[7:0] * 8'd3) ^ 8'h5A;
   endfunction

   assign data_in = mem_rd ? memf({ext_hi, addr_lo}) : 8'h00;

   dma_xfer_channel dut (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel),
      .prog_wdata(prog_wdata), .cfg_type(cfg_type), .cfg_block(cfg_block),
      .cfg_autoinit(cfg_autoinit), .dev_req(dev_req), .dev_ack(dev_ack),
      .bus_req(bus_req), .hold_grant(hold_grant), .addr_lo(addr_lo),
      .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
      .addr_stb(addr_stb), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
      .io_wr(io_wr), .tc(tc)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   // arbiter stand-in: grant follows request one clock later
   initial begin
      forever begin
         @(negedge clk);
         hold_grant = bus_req;
      end
   end

   // bus monitor and scoreboard
   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         bit ev, dstp, last;
         logic [15:0] ea;
         if (bus_req && !req_q) begin
            svc_cnt++;
            svc_stb   = 1'b0;
            mdl_valid = 1'b0;
         end
         req_q = bus_req;
         if (addr_stb) begin
            chk(!(mdl_valid && data_out == mdl_hi), "R4 redundant address cycle",
                {24'h0, data_out}, {24'h0, mdl_hi});
            ext_hi    = data_out;
            mdl_hi    = data_out;
            mdl_valid = 1'b1;
            svc_stb   = 1'b1;
         end
         ev = mem_rd || mem_wr || io_rd || io_wr;
         if (ev) begin
            dstp = (m_type == 2) && m_phase;
            ea   = dstp ? m_dst : m_src;
            chk({ext_hi, addr_lo} == ea, "R3 address", {16'h0, ext_hi, addr_lo}, {16'h0, ea});
            chk(svc_stb, "R4 first-cycle strobe", 0, 1);
            last = (m_left == 1) && (m_type != 2 || m_phase);
            chk(tc == last, "R5 terminal count", {31'h0, tc}, {31'h0, last});
            case (m_type)
               0: chk(mem_rd && io_wr && dev_ack && !mem_wr && !io_rd && !data_oe,
                      "R8 read strobes", {26'h0, mem_rd, io_wr, dev_ack, mem_wr, io_rd, data_oe},
                      32'h38);
               1: chk(io_rd && mem_wr && dev_ack && !mem_rd && !io_wr && !data_oe,
                      "R9 write strobes", {26'h0, io_rd, mem_wr, dev_ack, mem_rd, io_wr, data_oe},
                      32'h38);
               default: begin
                  if (!m_phase) begin
                     chk(mem_rd && !mem_wr && !io_rd && !io_wr && !dev_ack,
                         "R10 source read", {27'h0, mem_rd, mem_wr, io_rd, io_wr, dev_ack}, 32'h10);
                     m_temp = memf(ea);
                  end else begin
                     chk(mem_wr && !mem_rd && data_oe && !dev_ack && data_out == m_temp,
                         "R10 destination write", {24'h0, data_out}, {24'h0, m_temp});
                  end
               end
            endcase
            if (m_type == 2) begin
               if (!m_phase) m_src = m_src + 16'd1;
               else begin m_dst = m_dst + 16'd1; m_left--; end
               m_phase = !m_phase;
            end else begin
               m_src = m_src + 16'd1;
               m_left--;
            end
         end
      end else begin
         req_q = bus_req;
      end
   end

   task automatic prog(input logic [1:0] sel, input logic [15:0] val);
      @(posedge clk); #1;
      prog_we = 1'b1; prog_sel = sel; prog_wdata = val;
      @(posedge clk); #1;
      prog_we = 1'b0;
   endtask

   task automatic run(input int typ, input bit blk, input bit ai,
                      input logic [15:0] src, input logic [15:0] dst,
                      input int cnt, input bit reprog);
      bit seen;
      int svc0;
      if (reprog) begin
         prog(2'd0, src);
         prog(2'd1, dst);
         prog(2'd2, cnt[15:0]);
      end
      @(negedge clk);
      cfg_type = typ[1:0]; cfg_block = blk; cfg_autoinit = ai;
      m_type = typ; m_src = src; m_dst = dst; m_left = cnt + 1; m_phase = 1'b0;
      svc_cnt = 0;
      @(negedge clk);
      dev_req = 1'b1;
      seen = 1'b0;
      for (int k = 0; k < 5000 && !seen; k++) begin
         @(negedge clk);
         if (tc) begin seen = 1'b1; dev_req = 1'b0; end
      end
      dev_req = 1'b0;
      chk(seen, "R5 block reached terminal count", {31'h0, seen}, 1);
      repeat (4) @(negedge clk);
      chk(m_left == 0, "R5 bytes moved equals count plus one", m_left, 0);
      if (blk) chk(svc_cnt == 1, "R7 one bus tenure per block", svc_cnt, 1);
      else     chk(svc_cnt == cnt + 1, "R6 one bus tenure per byte", svc_cnt, cnt + 1);
      if (!ai) begin
         svc0 = svc_cnt;
         dev_req = 1'b1;
         repeat (10) @(negedge clk);
         chk(svc_cnt == svc0 && !bus_req, "R11 channel idle after terminal count",
             svc_cnt, svc0);
         dev_req = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog expired: got %0d cycles expected completion", 150000);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      chk(!bus_req && !tc && !dev_ack && !addr_stb && !data_oe && !mem_rd && !mem_wr
          && !io_rd && !io_wr, "R1 outputs in reset",
          {23'h0, bus_req, tc, dev_ack, addr_stb, data_oe, mem_rd, mem_wr, io_rd, io_wr}, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      chk(!bus_req && !tc && !data_oe, "R1 outputs after reset",
          {29'h0, bus_req, tc, data_oe}, 0);
      svc_cnt = 0;
      dev_req = 1'b1;
      repeat (10) @(negedge clk);
      chk(svc_cnt == 0 && !bus_req, "R1 request ignored before programming", svc_cnt, 0);
      dev_req = 1'b0;

      // directed corners
      run(0, 1'b0, 1'b0, 16'h12FF, 16'h0000, 0, 1'b1);   // single byte
      run(1, 1'b1, 1'b0, 16'hFFFE, 16'h0000, 3, 1'b1);   // R3 wrap to zero
      run(2, 1'b1, 1'b0, 16'h10FE, 16'h20FF, 4, 1'b1);   // m2m page crossings
      run(2, 1'b0, 1'b0, 16'h44FF, 16'h4500, 2, 1'b1);   // m2m single mode
      run(0, 1'b1, 1'b1, 16'h34F8, 16'h0000, 9, 1'b1);   // R2 auto reload
      run(0, 1'b1, 1'b1, 16'h34F8, 16'h0000, 9, 1'b0);   // R11 replay from bases
      run(1, 1'b0, 1'b1, 16'h77FD, 16'h0000, 5, 1'b1);
      run(1, 1'b0, 1'b0, 16'h77FD, 16'h0000, 5, 1'b0);   // R2 base kept

      // constrained random
      for (int i = 0; i < 40; i++) begin
         int typ, cnt;
         bit blk, ai;
         logic [15:0] s, d;
         typ = $urandom % 3;
         blk = $urandom % 2;
         ai  = $urandom % 2;
         cnt = $urandom % 24;
         s   = {8'($urandom), 8'hF0 | 8'($urandom % 16)};
         d   = {8'($urandom), 8'hE8 | 8'($urandom % 24)};
         run(typ, blk, ai, s, d, cnt, 1'b1);
         if (ai) run(typ, blk, 1'b0, s, d, cnt, 1'b0);
      end

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule